// File: doc/BRIEF.md
# General-Purpose DMA Sequencer with Clock Alignment

This block performs one fixed-direction block transfer on a console bus with two address spaces: a wide primary bus and a narrow peripheral page bus, sharing one data bus. A one-cycle start pulse, standing for the CPU's write to the enable register, holds the CPU off the bus. The sequencer then waits for an 8-clock grid counted from reset and spends a fixed setup interval. It moves the bytes one per 8-clock slot, spends a fixed teardown interval, and pads the stall until its total length is a multiple of 6 clocks. Then it releases the CPU.

In each byte slot, the sequencer reads from a primary address that steps by one per byte and writes to a peripheral register that stays fixed. The primary read strobe and the peripheral write strobe are driven low together for the last four clocks of the slot. The read data goes straight onto the write data lines. All timing is counted in master clocks. A byte count of zero means the full range of the count field.

Top module: `dma_gp_sequencer`

## Requirements
- R1: After reset, and whenever no transfer is running, `cpu_stall` and `busy` are 0, `done` is 0, and all four active-low strobes are 1.
- R2: A `start` pulse sampled while idle is accepted. `cpu_stall` and `busy` are 1 from the next cycle. Cycle n is the cycle after the n-th clock edge since reset. The pre-sync phase lasts until the first cycle s (with s > start cycle) where s mod 8 = 0.
- R3: Setup occupies cycles s to s+7, with no strobe asserted.
- R4: Byte i occupies cycles s+8+8i to s+15+8i. `a_rd_n` and `b_wr_n` are both 0 exactly in the last 4 cycles of that slot and are 1 in its first 4 cycles.
- R5: While byte i is strobed, `a_addr` equals the start address plus i, and `b_addr` equals the page latched at start.
- R6: A count value of 0 transfers 2^CNT_W bytes. Any other value transfers that many bytes.
- R7: Teardown lasts 8 cycles after the last byte. The stall then continues until its total length, counted from the first stall cycle, is the smallest multiple of 6 not shorter than pre-sync + setup + bytes + teardown.
- R8: `done` is 1 for exactly the one cycle after the last stall cycle.
- R9: A `start` pulse while busy is ignored. The running transfer's timing, addresses and length are unchanged.
- R10: `a_wr_n` and `b_rd_n` stay 1 at all times. While the strobes are asserted, `dout` equals `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Enable-register write pulse |
| src_addr | input | ADDR_W | First primary-bus address |
| dst_page | input | PAGE_W | Peripheral register address |
| byte_cnt | input | CNT_W | Byte count, 0 = 2^CNT_W |
| din | input | DATA_W | Data read from the primary bus |
| dout | output | DATA_W | Data driven for the peripheral write |
| a_addr | output | ADDR_W | Primary bus address |
| b_addr | output | PAGE_W | Peripheral bus address |
| a_rd_n | output | 1 | Primary read strobe, active low |
| a_wr_n | output | 1 | Primary write strobe, active low |
| b_rd_n | output | 1 | Peripheral read strobe, active low |
| b_wr_n | output | 1 | Peripheral write strobe, active low |
| cpu_stall | output | 1 | Holds the CPU off the bus |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench launches transfers at every kind of grid phase, including the cycle just before the 8-clock boundary, where the pre-sync phase is zero clocks long. It also launches on the boundary itself, where the pre-sync phase is seven clocks long. A design that misaligned these cases would strobe one or more grid slots off. The runs use lengths chosen so that the 6-clock padding takes several different values, including zero. A miscount there would release the CPU early or late and move the `done` pulse. A zero count is run to its full length to catch a design that treats zero as an empty transfer. A second start pulse fired mid-transfer would restart or lengthen a design that failed to ignore it.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA sequencer.
// Assumes: one transfer at a time, primary-to-peripheral direction only.
package dma_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SETUP,
        PH_XFER,
        PH_TEAR,
        PH_POST
    } phase_t;
endpackage

// File: rtl/dma_align_timer.sv
// Alignment counters: a free-running grid counter since reset and a
// counter of stall cycles modulo the release multiple.
// Assumes: in_seq is high exactly for the stall cycles.
module dma_align_timer #(
    parameter int PRE_ALIGN  = 8,
    parameter int POST_ALIGN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_seq,
    output logic grid_zero,
    output logic pre_last,
    output logic post_last
);
    localparam int GW = (PRE_ALIGN  > 1) ? $clog2(PRE_ALIGN)  : 1;
    localparam int PW = (POST_ALIGN > 1) ? $clog2(POST_ALIGN) : 1;
    localparam logic [GW-1:0] G_LAST = GW'(PRE_ALIGN - 1);
    localparam logic [PW-1:0] P_LAST = PW'(POST_ALIGN - 1);

    logic [GW-1:0] grid_q;
    logic [PW-1:0] post_q;

    // Grid counter: clock count since reset, modulo PRE_ALIGN.
    always_ff @(posedge clk) begin
        if (!rst_n)               grid_q <= '0;
        else if (grid_q == G_LAST) grid_q <= '0;
        else                      grid_q <= grid_q + 1'b1;
    end

    // Stall-length counter modulo POST_ALIGN, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_seq)     post_q <= '0;
        else if (post_q == P_LAST) post_q <= '0;
        else                       post_q <= post_q + 1'b1;
    end

    assign grid_zero = (grid_q == '0);
    assign pre_last  = (grid_q == G_LAST);
    assign post_last = in_seq && (post_q == P_LAST);

    // R7: the release counter only moves during a stall.
    a_r7_post_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_seq |=> (post_q == '0) || in_seq);
endmodule

// File: rtl/dma_phase_timer.sv
// Counts clocks inside one fixed-length interval (setup, byte slot,
// teardown) and flags the interval's last clock.
// Assumes: last_val is held stable while run is high within an interval.
module dma_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] last_val,
    output logic [W-1:0] sub,
    output logic         at_end
);
    assign at_end = run && (sub == last_val);

    // Interval counter: restarts at zero after each interval's last clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || at_end) sub <= '0;
        else                          sub <= sub + 1'b1;
    end

    // R4: the counter never runs past the interval end.
    a_r4_sub_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> sub <= last_val);
endmodule

// File: rtl/dma_byte_engine.sv
// Holds the primary address and the bytes still to move.
// Assumes: load and advance are never high together.
module dma_byte_engine #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              advance,
    input  logic              xfer,
    output logic [ADDR_W-1:0] addr,
    output logic              last_byte
);
    localparam int RW = CNT_W + 1;
    localparam logic [RW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

    logic [RW-1:0] rem_q;

    // Address and remaining-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            rem_q <= '0;
        end else if (load) begin
            addr  <= load_addr;
            rem_q <= (load_cnt == '0) ? FULL : {1'b0, load_cnt};
        end else if (advance) begin
            addr  <= addr + 1'b1;
            rem_q <= rem_q - 1'b1;
        end
    end

    assign last_byte = (rem_q == RW'(1));

    // R6: a running transfer always has at least one byte left.
    a_r6_rem_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> rem_q != '0);
    // R5: each advance steps the address by exactly one.
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/dma_gp_sequencer.sv
// General-purpose DMA sequencer: stalls the CPU, aligns to the clock
// grid, runs setup, byte slots and teardown, pads the stall to the
// release multiple, then pulses done.
// Assumes: start is a one-cycle pulse; strobes are active low.
module dma_gp_sequencer
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PAGE_W      = 8,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 8,
    parameter int PRE_ALIGN   = 8,
    parameter int POST_ALIGN  = 6,
    parameter int SETUP_CLKS  = 8,
    parameter int BYTE_CLKS   = 8,
    parameter int STROBE_CLKS = 4,
    parameter int TEAR_CLKS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [PAGE_W-1:0] dst_page,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [ADDR_W-1:0] a_addr,
    output logic [PAGE_W-1:0] b_addr,
    output logic              a_rd_n,
    output logic              a_wr_n,
    output logic              b_rd_n,
    output logic              b_wr_n,
    output logic              cpu_stall,
    output logic              busy,
    output logic              done
);
    localparam int MAX_A = (SETUP_CLKS > TEAR_CLKS) ? SETUP_CLKS : TEAR_CLKS;
    localparam int MAX_U = (MAX_A > BYTE_CLKS) ? MAX_A : BYTE_CLKS;
    localparam int SW    = (MAX_U > 1) ? $clog2(MAX_U) : 1;
    localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_CLKS - 1);
    localparam logic [SW-1:0] BYTE_LAST  = SW'(BYTE_CLKS - 1);
    localparam logic [SW-1:0] TEAR_LAST  = SW'(TEAR_CLKS - 1);
    localparam logic [SW-1:0] STRB_FIRST = SW'(BYTE_CLKS - STROBE_CLKS);

    phase_t            ph_q, ph_d;
    logic              grid_zero, pre_last, post_last;
    logic              run, at_end, last_byte, advance, load, strobe;
    logic [SW-1:0]     sub, last_val;
    logic [PAGE_W-1:0] page_q;
    logic              done_q;

    assign load    = (ph_q == PH_IDLE) && start;
    assign run     = (ph_q == PH_SETUP) || (ph_q == PH_XFER) || (ph_q == PH_TEAR);
    assign advance = (ph_q == PH_XFER) && at_end && !last_byte;
    assign strobe  = (ph_q == PH_XFER) && (sub >= STRB_FIRST);

    dma_align_timer #(.PRE_ALIGN(PRE_ALIGN), .POST_ALIGN(POST_ALIGN)) u_align (
        .clk(clk), .rst_n(rst_n), .in_seq(ph_q != PH_IDLE),
        .grid_zero(grid_zero), .pre_last(pre_last), .post_last(post_last)
    );

    dma_phase_timer #(.W(SW)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .last_val(last_val),
        .sub(sub), .at_end(at_end)
    );

    dma_byte_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(src_addr),
        .load_cnt(byte_cnt), .advance(advance), .xfer(ph_q == PH_XFER),
        .addr(a_addr), .last_byte(last_byte)
    );

    // Interval length selected by the current phase.
    always_comb begin
        case (ph_q)
            PH_SETUP: last_val = SETUP_LAST;
            PH_TEAR:  last_val = TEAR_LAST;
            default:  last_val = BYTE_LAST;
        endcase
    end

    // Phase sequencing.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE:  if (start)     ph_d = pre_last ? PH_SETUP : PH_PRE;
            PH_PRE:   if (pre_last)  ph_d = PH_SETUP;
            PH_SETUP: if (at_end)    ph_d = PH_XFER;
            PH_XFER:  if (at_end && last_byte) ph_d = PH_TEAR;
            PH_TEAR:  if (at_end)    ph_d = post_last ? PH_IDLE : PH_POST;
            PH_POST:  if (post_last) ph_d = PH_IDLE;
            default:                 ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Peripheral page latch, captured with the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    page_q <= '0;
        else if (load) page_q <= dst_page;
    end

    // Completion pulse in the cycle after the stall ends.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (ph_q != PH_IDLE) && (ph_d == PH_IDLE);
    end

    assign cpu_stall = (ph_q != PH_IDLE);
    assign busy      = cpu_stall;
    assign done      = done_q;
    assign b_addr    = page_q;
    assign a_rd_n    = !strobe;
    assign b_wr_n    = !strobe;
    assign a_wr_n    = 1'b1;
    assign b_rd_n    = 1'b1;
    assign dout      = din;

    // R1: no strobe while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> a_rd_n && b_wr_n);
    // R2: an accepted start raises the stall on the next cycle.
    a_r2_stall_next: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE && start) |=> cpu_stall);
    // R3: setup begins on the grid.
    a_r3_setup_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SETUP && sub == '0) |-> grid_zero);
    // R8: done follows the last stall cycle.
    a_r8_done_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cpu_stall && $past(cpu_stall));
endmodule

// File: tb/dma_gp_sequencer_test.sv
module dma_gp_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    logic        clk = 0, rst_n = 0, start = 0;
    logic [23:0] src_addr = '0;
    logic [7:0]  dst_page = '0;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [23:0] a_addr;
    logic [7:0]  b_addr;
    logic a_rd_n, a_wr_n, b_rd_n, b_wr_n, cpu_stall, busy, done;

    int cyc = 0;
    int checks = 0, errors = 0;
    int t0 = -100000, s_al = 0, nb = 0, total = 0;
    logic [23:0] m_addr;
    logic [7:0]  m_page;
    bit run_on = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_gp_sequencer #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_page(dst_page), .byte_cnt(byte_cnt), .din(din), .dout(dout),
        .a_addr(a_addr), .b_addr(b_addr), .a_rd_n(a_rd_n), .a_wr_n(a_wr_n),
        .b_rd_n(b_rd_n), .b_wr_n(b_wr_n), .cpu_stall(cpu_stall),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        din <= 8'((cyc * 37 + 11) & 255);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // Reference model, compared every clock.
    always @(negedge clk) begin
        if (rst_n && run_on) begin
            bit act, stb;
            int rel;
            act = (cyc > t0) && (cyc <= t0 + total);
            rel = cyc - (s_al + 8);
            stb = act && rel >= 0 && rel < 8 * nb && (rel % 8) >= 4;
            chk(cpu_stall == act, act ? "R2/R7 stall" : "R1 stall", cpu_stall, act);
            chk(busy == act, "R9 busy", busy, act);
            chk(done == (cyc == t0 + total + 1), "R8 done", done, cyc == t0 + total + 1);
            chk(a_rd_n == !stb, "R4 a_rd_n", a_rd_n, !stb);
            chk(b_wr_n == !stb, "R3/R4 b_wr_n", b_wr_n, !stb);
            chk(a_wr_n && b_rd_n, "R10 unused strobes", {a_wr_n, b_rd_n}, 3);
            if (stb) begin
                chk(a_addr == m_addr + 24'(rel / 8), "R5 a_addr", a_addr, m_addr + 24'(rel / 8));
                chk(b_addr == m_page, "R5 b_addr", b_addr, m_page);
                chk(dout == din, "R10 dout", dout, din);
            end
        end
    end

    task automatic launch(input int phase, input logic [23:0] a,
                          input logic [7:0] p, input int cnt, input int extra_start);
        int base;
        do begin @(posedge clk); #1; end while ((cyc % 8) != phase);
        start = 1; src_addr = a; dst_page = p; byte_cnt = CNT_W'(cnt);
        t0 = cyc; m_addr = a; m_page = p;
        nb = (cnt == 0) ? (1 << CNT_W) : cnt;
        s_al = ((t0 + 1 + 7) / 8) * 8;
        base = (s_al - (t0 + 1)) + 8 + 8 * nb + 8;
        total = ((base + 5) / 6) * 6;
        @(posedge clk); #1;
        start = 0; src_addr = ~a; dst_page = ~p; byte_cnt = CNT_W'(3);
        if (extra_start > 0) begin
            // R9: a second pulse mid-transfer must be ignored.
            repeat (extra_start) @(posedge clk);
            #1; start = 1;
            @(posedge clk); #1; start = 0;
        end
        while (cyc <= t0 + total + 4) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!cpu_stall && !busy && !done, "R1 reset outputs", {cpu_stall, busy, done}, 0);
        chk(a_rd_n && a_wr_n && b_rd_n && b_wr_n, "R1 reset strobes",
            {a_rd_n, a_wr_n, b_rd_n, b_wr_n}, 15);
        run_on = 1;
        launch(7, 24'h00F400, 8'h18, 1, 0);   // R2 zero-length pre-sync
        launch(2, 24'h12FFFE, 8'h04, 3, 0);   // R5 address carry
        launch(0, 24'h000100, 8'hA0, 2, 0);   // R2 seven-clock pre-sync
        launch(5, 24'h3C0000, 8'h22, 5, 20);  // R9 start while busy
        launch(3, 24'h7FFF80, 8'h11, 4, 0);   // R7 padding
        launch(6, 24'h000000, 8'h80, 0, 0);   // R6 zero count
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule